// File: doc/BRIEF.md
# Command Ring Fetch Pointer Controller

This block walks a ring of 32-bit commands that lives in system memory and hands them, in order, to a downstream consumer. The ring has 2**PTR_W entries (256 by default), each four bytes. Software places commands in the ring and then moves a write pointer to the offset of the last valid entry. While the run bit is set, the block reads each following entry over a single-outstanding memory read port, moves its read pointer forward as each response arrives, and pushes the command into a small prefetch FIFO that the consumer drains through a valid/ready port.

A register port gives access to the run bit, the 64-bit ring base (two 32-bit halves), the write pointer and the read pointer. Writing 1 to the read pointer's reset bit while the engine is stopped sends the pointer to zero and flushes the prefetch FIFO. Software then sees the bit read back as 1, writes 0, and sees 0. Base writes and reset requests that arrive while the engine is active are dropped. Stopping the engine lets a fetch that is already in flight finish, and no new fetch is issued after that.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset, the read pointer, the write pointer, both base halves and the run bit read 0, and neither mem_req_valid nor cmd_valid is asserted.
- R2: Register index 3 (write pointer) stores cfg_wdata[7:0] and returns it in bits 7:0. Bits 31:8 read 0 whatever was written.
- R3: While running, the block fetches entries until the read pointer equals the write pointer and then issues no further request. A write pointer update accepted while running resumes fetching up to the new value.
- R4: Each request address is {base_hi, base_lo} + ((read pointer + 1) mod 256) * 4. The read pointer advances by exactly one, wrapping from 255 to 0, when the response is accepted, and the commands reach cmd_data in ring order.
- R5: Register index 4 (read pointer) returns the read pointer in bits 7:0. Bits 14:8 and 31:16 read 0.
- R6: Writing cfg_wdata[15]=1 to index 4 while the engine is stopped sets the read pointer to 0 and empties the prefetch FIFO, and bit 15 reads 1 from the next cycle on. While bit 15 is 1 no fetch starts. Writing bit 15 = 0 clears it.
- R7: While the run bit is set or a fetch is outstanding, writes to the base registers (index 1 low half, index 2 high half) and reset requests through index 4 are ignored.
- R8: Indices 1 and 2 hold the low and high 32 bits of the ring base and read back what was written while the engine is stopped.
- R9: Index 0 bit 0 is the run bit. When it is 0 no new request is raised. Clearing it during a fetch lets that fetch complete, which advances the pointer once, and nothing follows.
- R10: The prefetch FIFO holds 4 commands. Fetching stalls while it is full, and cmd_data stays stable while cmd_valid is high and cmd_ready is low.
- R11: Once mem_req_valid rises it stays high with a stable mem_req_addr until mem_req_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index (0 run, 1 base low, 2 base high, 3 write ptr, 4 read ptr) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | 64 | Byte address of the entry to fetch |
| mem_rsp_valid | input | 1 | Fetch response valid |
| mem_rsp_data | input | 32 | Fetched command word |
| cmd_valid | output | 1 | Prefetched command available |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_data | output | 32 | Oldest prefetched command |

## Verification
The bench sweeps the write pointer more than once around the ring in uneven steps while the consumer and the memory model stall at irregular points. A pointer that fails to wrap, or an address off by one entry, shows up as a wrong command word. It fills the FIFO with the consumer held off to catch a design that overruns it or keeps fetching, and it resets the pointer with entries still queued to catch a design that leaves stale commands behind. It also clears the run bit in the middle of a slow fetch: a design that drops the response would leave the pointer short, and one that keeps going would leave it too far on. Base writes and reset requests made while running must leave the readback unchanged.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
   localparam int REG_IDX_W = 3;
   localparam logic [REG_IDX_W-1:0] REG_CTRL    = 3'd0;
   localparam logic [REG_IDX_W-1:0] REG_BASE_LO = 3'd1;
   localparam logic [REG_IDX_W-1:0] REG_BASE_HI = 3'd2;
   localparam logic [REG_IDX_W-1:0] REG_WPTR    = 3'd3;
   localparam logic [REG_IDX_W-1:0] REG_RPTR    = 3'd4;
   localparam int RST_BIT  = 15;
   localparam int MEM_AW   = 64;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_WAIT = 2'd2
   } fetch_state_e;
endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
   import cmdring_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [REG_IDX_W-1:0] cfg_addr,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   input  logic                 engine_busy,
   input  logic [PTR_W-1:0]     rd_ptr,
   output logic                 run,
   output logic [MEM_AW-1:0]    base_addr,
   output logic [PTR_W-1:0]     wr_ptr,
   output logic                 rptr_rst_req,
   output logic                 rptr_rst_hold
);
   logic [31:0] base_lo;
   logic [31:0] base_hi;
   logic        active;

   assign active       = run | engine_busy;
   assign base_addr    = {base_hi, base_lo};
   assign rptr_rst_req = cfg_we && (cfg_addr == REG_RPTR) && cfg_wdata[RST_BIT] && !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run           <= 1'b0;
         base_lo       <= '0;
         base_hi       <= '0;
         wr_ptr        <= '0;
         rptr_rst_hold <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_addr)
            REG_CTRL:    run <= cfg_wdata[0];
            REG_BASE_LO: if (!active) base_lo <= cfg_wdata;
            REG_BASE_HI: if (!active) base_hi <= cfg_wdata;
            REG_WPTR:    wr_ptr <= cfg_wdata[PTR_W-1:0];
            REG_RPTR: begin
               if (rptr_rst_req)
                  rptr_rst_hold <= 1'b1;
               else if (!cfg_wdata[RST_BIT])
                  rptr_rst_hold <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         REG_CTRL:    cfg_rdata[0] = run;
         REG_BASE_LO: cfg_rdata = base_lo;
         REG_BASE_HI: cfg_rdata = base_hi;
         REG_WPTR:    cfg_rdata[PTR_W-1:0] = wr_ptr;
         REG_RPTR: begin
            cfg_rdata[PTR_W-1:0] = rd_ptr;
            cfg_rdata[RST_BIT]   = rptr_rst_hold;
         end
         default: cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
   import cmdring_pkg::*;
#(
   parameter int PTR_W = 8,
   parameter int CMD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [MEM_AW-1:0] base_addr,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic              rptr_rst_req,
   input  logic              rptr_rst_hold,
   input  logic              fifo_full,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [MEM_AW-1:0] req_addr,
   input  logic              rsp_valid,
   input  logic [CMD_W-1:0]  rsp_data,
   output logic              push,
   output logic [CMD_W-1:0]  push_data,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              busy
);
   fetch_state_e state;
   logic [PTR_W-1:0] nxt_idx;
   logic             start;

   assign nxt_idx   = rd_ptr + 1'b1;
   assign req_addr  = base_addr + MEM_AW'({nxt_idx, 2'b00});
   assign start     = run && !rptr_rst_hold && (rd_ptr != wr_ptr) && !fifo_full;
   assign req_valid = (state == FS_REQ);
   assign push      = (state == FS_WAIT) && rsp_valid;
   assign push_data = rsp_data;
   assign busy      = (state != FS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= FS_IDLE;
         rd_ptr <= '0;
      end else begin
         case (state)
            FS_IDLE: if (start) state <= FS_REQ;
            FS_REQ:  if (req_ready) state <= FS_WAIT;
            FS_WAIT: if (rsp_valid) begin
               state  <= FS_IDLE;
               rd_ptr <= nxt_idx;
            end
            default: state <= FS_IDLE;
         endcase
         if (rptr_rst_req) rd_ptr <= '0;
      end
   end
endmodule

// File: rtl/cmdring_fifo.sv
module cmdring_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [W-1:0]     out_data,
   output logic [LVL_W-1:0] level,
   output logic             full
);
   logic [W-1:0]     slot [DEPTH];
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   logic             pop;

   assign out_valid = (level != '0);
   assign out_data  = slot[rd_idx];
   assign pop       = out_valid && out_ready;
   assign full      = (level == LVL_W'(DEPTH));

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && (wr_idx == IDX_W'(i))) slot[i] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_idx <= '0;
         rd_idx <= '0;
         level  <= '0;
      end else begin
         if (push) wr_idx <= wr_idx + 1'b1;
         if (pop)  rd_idx <= rd_idx + 1'b1;
         level <= level + LVL_W'(push) - LVL_W'(pop);
      end
   end
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
   import cmdring_pkg::*;
#(
   parameter int PTR_W      = 8,
   parameter int CMD_W      = 32,
   parameter int FIFO_DEPTH = 4,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   output logic        mem_req_valid,
   input  logic        mem_req_ready,
   output logic [63:0] mem_req_addr,
   input  logic        mem_rsp_valid,
   input  logic [31:0] mem_rsp_data,
   output logic        cmd_valid,
   input  logic        cmd_ready,
   output logic [31:0] cmd_data
);
   if (PTR_W < 2 || PTR_W > RST_BIT) begin : g_bad_ptr
      $error("PTR_W must lie between 2 and 15");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (CMD_W != 32) begin : g_bad_cmd
      $error("CMD_W must be 32");
   end

   logic              run;
   logic [MEM_AW-1:0] base_addr;
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic              rptr_rst_req;
   logic              rptr_rst_hold;
   logic              engine_busy;
   logic              fifo_full;
   logic              fifo_push;
   logic [CMD_W-1:0]  fifo_push_data;
   logic [LVL_W-1:0]  fifo_level;

   cmdring_regs #(.PTR_W(PTR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .engine_busy(engine_busy),
      .rd_ptr(rd_ptr), .run(run), .base_addr(base_addr), .wr_ptr(wr_ptr),
      .rptr_rst_req(rptr_rst_req), .rptr_rst_hold(rptr_rst_hold)
   );

   cmdring_fetch #(.PTR_W(PTR_W), .CMD_W(CMD_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .run(run), .base_addr(base_addr), .wr_ptr(wr_ptr),
      .rptr_rst_req(rptr_rst_req), .rptr_rst_hold(rptr_rst_hold), .fifo_full(fifo_full),
      .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
      .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .push(fifo_push),
      .push_data(fifo_push_data), .rd_ptr(rd_ptr), .busy(engine_busy)
   );

   cmdring_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(rptr_rst_req), .push(fifo_push),
      .push_data(fifo_push_data), .out_valid(cmd_valid), .out_ready(cmd_ready),
      .out_data(cmd_data), .level(fifo_level), .full(fifo_full)
   );
endmodule

// File: rtl/cmdring_chk.sv
module cmdring_chk #(
   parameter int PTR_W      = 8,
   parameter int FIFO_DEPTH = 4,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             engine_busy,
   input logic [PTR_W-1:0] rd_ptr,
   input logic [PTR_W-1:0] wr_ptr,
   input logic [63:0]      base_addr,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [63:0]      mem_req_addr,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [31:0]      cmd_data,
   input logic [LVL_W-1:0] fifo_level,
   input logic             fifo_push,
   input logic             rptr_rst_req
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> fifo_level < LVL_W'(FIFO_DEPTH)); // R10
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(FIFO_DEPTH)); // R10
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready && !rptr_rst_req |=> cmd_valid && $stable(cmd_data)); // R10
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_ptr) |-> (PTR_W'(rd_ptr - $past(rd_ptr)) == PTR_W'(1)) || (rd_ptr == '0)); // R4
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !$rose(mem_req_valid)); // R9
   AST_BASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (run || engine_busy) |=> $stable(base_addr)); // R7
   AST_NO_FETCH_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> $past(rd_ptr) != $past(wr_ptr)); // R3
endmodule

bind cmd_ring_fetch cmdring_chk #(.PTR_W(PTR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .engine_busy(engine_busy), .rd_ptr(rd_ptr),
   .wr_ptr(wr_ptr), .base_addr(base_addr), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready), .cmd_data(cmd_data), .fifo_level(fifo_level),
   .fifo_push(fifo_push), .rptr_rst_req(rptr_rst_req)
);

// File: tb/sim_cmd_ring_fetch.sv
module sim_cmd_ring_fetch;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] I_CTRL = 3'd0, I_BLO = 3'd1, I_BHI = 3'd2, I_WP = 3'd3, I_RP = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [63:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        cmd_valid;
   logic        cmd_ready;
   logic [31:0] cmd_data;

   int          n_chk = 0;
   int          n_fail = 0;
   int          rx_cnt = 0;
   int          rx_base_cnt = 0;
   int          req_cnt = 0;
   int          cons_mode = 1;
   bit          mem_slow = 1'b0;
   logic [63:0] exp_base = '0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_ring_fetch u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
   );

   function automatic logic [31:0] mem_word(input logic [63:0] a);
      return a[31:0] ^ a[63:32] ^ 32'hC0DE_0000;
   endfunction

   function automatic logic [31:0] exp_word(input int k);
      logic [7:0] idx;
      idx = 8'(k + 1);
      return mem_word(exp_base + 64'({idx, 2'b00}));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = idx;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_rx(input int target, input string req);
      for (int i = 0; i < 4000 && rx_cnt < target; i++) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(rx_cnt == target, req, "received count", 64'(rx_cnt), 64'(target));
   endtask

   // memory model: one request at a time, irregular accept delay and latency
   initial begin
      logic [7:0]  lfsr;
      logic [63:0] cap;
      lfsr = 8'h5B;
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            repeat (int'(lfsr[1:0])) @(negedge clk);
            mem_req_ready = 1'b1;
            cap = mem_req_addr;
            @(negedge clk);
            mem_req_ready = 1'b0;
            req_cnt++;
            repeat (mem_slow ? 10 : int'(lfsr[3:2])) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(cap);
         end
      end
   end

   // consumer: checks every accepted command against the ring order (R4)
   initial begin
      logic [7:0] pat;
      pat = 8'hA7;
      cmd_ready = 1'b0;
      forever begin
         @(negedge clk);
         pat = {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
         cmd_ready = (cons_mode == 0) ? 1'b1 : (cons_mode == 1) ? 1'b0 : pat[0];
         if (cmd_valid && cmd_ready) begin
            chk(cmd_data == exp_word(rx_cnt - rx_base_cnt), "R4", "command word",
                64'(cmd_data), 64'(exp_word(rx_cnt - rx_base_cnt)));
            rx_cnt++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] d2;
      logic [7:0]  wp;
      logic [7:0]  cur;
      int          target;
      int          reqs0;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(I_RP, d);   chk(d == 0, "R1", "read pointer", 64'(d), 0);
      rd(I_WP, d);   chk(d == 0, "R1", "write pointer", 64'(d), 0);
      rd(I_BHI, d);  chk(d == 0, "R1", "base high", 64'(d), 0);
      rd(I_BLO, d);  chk(d == 0, "R1", "base low", 64'(d), 0);
      rd(I_CTRL, d); chk(d == 0, "R1", "run bit", 64'(d), 0);
      chk(!mem_req_valid && !cmd_valid, "R1", "request/cmd idle", 64'({mem_req_valid, cmd_valid}), 0);

      // R2: write pointer field and reserved bits
      wr(I_WP, 32'h0000_FFFF); rd(I_WP, d); chk(d == 32'hFF, "R2", "wp all ones", 64'(d), 64'h FF);
      wr(I_WP, 32'h0000_1200); rd(I_WP, d); chk(d == 32'h0, "R2", "wp reserved only", 64'(d), 0);

      // R8: base registers while stopped
      wr(I_BLO, 32'h0001_2000); wr(I_BHI, 32'hDEAD_0001);
      exp_base = 64'hDEAD_0001_0001_2000;
      rd(I_BLO, d); chk(d == 32'h0001_2000, "R8", "base low", 64'(d), 64'h0001_2000);
      rd(I_BHI, d); chk(d == 32'hDEAD_0001, "R8", "base high", 64'(d), 64'hDEAD_0001);

      // R9: stopped engine raises nothing
      wr(I_WP, 32'd5);
      repeat (20) @(negedge clk);
      chk(req_cnt == 0, "R9", "requests while stopped", 64'(req_cnt), 0);

      // R3: run up to wp then idle
      cons_mode = 0;
      wr(I_CTRL, 32'd1);
      wait_rx(5, "R3");
      rd(I_RP, d); chk(d == 32'd5, "R5", "rp after five", 64'(d), 5);
      chk(req_cnt == 5, "R3", "no fetch past wp", 64'(req_cnt), 5);

      // R7: base write and reset request ignored while running
      wr(I_BHI, 32'h1111_2222); rd(I_BHI, d);
      chk(d == 32'hDEAD_0001, "R7", "base high locked", 64'(d), 64'hDEAD_0001);
      wr(I_RP, 32'h0000_8000); rd(I_RP, d);
      chk(d == 32'd5, "R7", "reset ignored while running", 64'(d), 5);

      // R3/R4: wp moved in uneven steps, more than once around the ring
      cons_mode = 2;
      wp = 8'd5; target = 5;
      for (int s = 0; s < 9; s++) begin
         wp = wp + 8'(23 + 7 * s);
         target = target + 23 + 7 * s;
         wr(I_WP, {24'h0, wp});
         if (s % 3 == 2) continue;
         wait_rx(target, "R3");
         rd(I_RP, d); chk(d == {24'h0, wp}, "R4", "rp equals wp after step", 64'(d), 64'(wp));
      end
      wait_rx(target, "R3");
      rd(I_RP, d); chk(d == {24'h0, wp}, "R4", "rp after wrap sweep", 64'(d), 64'(wp));
      chk(d[15:8] == 0, "R5", "rp reserved bits", 64'(d[15:8]), 0);

      // R10: FIFO fills and fetching stalls
      cons_mode = 1;
      repeat (3) @(negedge clk);
      cur = d[7:0]; reqs0 = req_cnt;
      wr(I_WP, {24'h0, 8'(cur + 8'd10)});
      repeat (80) @(negedge clk);
      rd(I_RP, d); chk(d[7:0] == 8'(cur + 8'd4), "R10", "rp stops at fifo depth", 64'(d), 64'(8'(cur + 8'd4)));
      chk(req_cnt - reqs0 == 4, "R10", "requests while full", 64'(req_cnt - reqs0), 4);
      d = cmd_data; @(negedge clk); @(negedge clk); d2 = cmd_data;
      chk(cmd_valid && d == d2 && d2 == exp_word(rx_cnt - rx_base_cnt), "R10", "held head word",
          64'(d2), 64'(exp_word(rx_cnt - rx_base_cnt)));
      cons_mode = 0;
      target = target + 10;
      wait_rx(target, "R10");

      // R6: reset with queued entries
      cons_mode = 1;
      wr(I_WP, {24'h0, 8'(cur + 8'd13)});
      repeat (40) @(negedge clk);
      wr(I_CTRL, 32'd0);
      repeat (20) @(negedge clk);
      chk(cmd_valid == 1'b1, "R6", "entries queued before reset", 64'(cmd_valid), 1);
      wr(I_RP, 32'h0000_8000);
      rd(I_RP, d); chk(d == 32'h0000_8000, "R6", "reset bit set, rp zero", 64'(d), 64'h8000);
      chk(cmd_valid == 1'b0, "R6", "fifo flushed", 64'(cmd_valid), 0);
      rx_base_cnt = rx_cnt;
      wr(I_WP, 32'd3);
      reqs0 = req_cnt;
      wr(I_CTRL, 32'd1);
      repeat (30) @(negedge clk);
      chk(req_cnt == reqs0, "R6", "no fetch while reset bit held", 64'(req_cnt - reqs0), 0);
      wr(I_CTRL, 32'd0);
      wr(I_RP, 32'h0);
      rd(I_RP, d); chk(d == 32'h0, "R6", "reset bit cleared", 64'(d), 0);
      wr(I_BLO, 32'h0000_7000); wr(I_BHI, 32'h0);
      exp_base = 64'h7000;
      cons_mode = 0;
      wr(I_CTRL, 32'd1);
      wait_rx(rx_base_cnt + 3, "R6");
      rd(I_RP, d); chk(d == 32'd3, "R6", "rp after restart", 64'(d), 3);

      // R9: stop during a slow fetch
      mem_slow = 1'b1;
      reqs0 = req_cnt;
      wr(I_WP, 32'd10);
      for (int i = 0; i < 200 && req_cnt == reqs0; i++) @(negedge clk);
      wr(I_CTRL, 32'd0);
      repeat (60) @(negedge clk);
      rd(I_RP, d); chk(d == 32'd4, "R9", "in-flight fetch completes", 64'(d), 4);
      chk(req_cnt - reqs0 == 1, "R9", "no request after stop", 64'(req_cnt - reqs0), 1);
      chk(rx_cnt == rx_base_cnt + 4, "R9", "delivered after stop", 64'(rx_cnt - rx_base_cnt), 4);

      done = 1'b1;
      finish_up();
   end
endmodule